// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block gathers ten peripheral interrupt lines on a board-level logic device and folds them into one active-low request line for a host processor that watches for falling edges. Every input passes through a two-flop synchroniser and a history flop, then through a per-source detector whose trigger condition is chosen by a 3-bit mode field: falling edge, rising edge, either edge, low level or high level. A detected trigger sets a sticky status bit. The status bit is recorded whether or not the source is masked. The request line is low while any status bit is set and its mask bit is clear.

Software reaches the block through a small synchronous 16-bit register port with one write strobe and a combinational read. Through it, software clears status bits by writing zeros, programs the mask and the trigger modes, drives active-low reset lines to external peripherals and reads a fixed identification word. The host input is edge-sensitive. Software therefore forces a fresh falling edge by writing all ones to the mask and then writing back its working mask. If unmasked status is still pending, the line drops again.

Top module: `intagg_top`

## Requirements
- R1: After reset, all status bits are 0, the mask reads 16'hFFFF, both mode registers read 0, the reset-control register reads 0, `periph_rst_n` is all 0 and `irq_n` is 1.
- R2: In edge modes (code 0 falling, 1 rising, 2 either edge), a transition sets the status bit exactly once, and a transition of the opposite direction has no effect in single-edge modes. An input change before clock edge k is visible in status after edge k+2.
- R3: In level modes (code 3 active low, 4 active high), the status bit is set on every cycle while the level is present, so a clear written during that time leaves the bit set.
- R4: Mode codes 5, 6 and 7 never set status.
- R5: A write to address 1 clears each status bit whose data bit is 0 and keeps each bit whose data bit is 1. A trigger in the same cycle wins over the clear. Address 1 reads status in bits 9:0 and zeros above.
- R6: A status bit latches on its trigger even while the source is masked.
- R7: `irq_n` is 0 exactly when some status bit n is 1 while mask bit n (address 2, 1 = masked) is 0. It follows a mask or status change in the cycle after the write edge.
- R8: Writing 16'hFFFF to address 2 drives `irq_n` to 1 in the next cycle. Writing back a partial mask drives it low again when unmasked status is pending.
- R9: Source n < 5 has its mode at bits 3n+2:3n of address 4. Source n >= 5 has its mode at bits 3(n-5)+2:3(n-5) of address 5. Bit 15 of both registers reads 0.
- R10: Address 0 reads the board number in bits 15:8 and the version in bits 7:0 (defaults 8'h03 and 8'h17), and writes to it have no effect.
- R11: Address 3 bit k drives `periph_rst_n[k]` (0 holds the peripheral in reset, 1 releases it), reads back, and changes only on a write to address 3.
- R12: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 10 | Raw peripheral interrupt inputs, asynchronous |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Merged active-low request to the host |
| periph_rst_n | output | 8 | Active-low reset lines to external peripherals |

## Verification
The two functions that can meet in one cycle are a detected trigger and a software clear of the same status bit. The bench provokes this by holding a high-level source active while writing a zero to its status bit, so the trigger and the clear land on the same edge. It judges the outcome by reading status back and expecting the bit still set. The same overlap arises when an edge lands on the clear cycle. A cycle-accurate behavioural model in the bench sees every such overlap and compares `irq_n`, `periph_rst_n` and the read data against the design on every clock.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    // Register map
    localparam int ADDR_ID     = 0;
    localparam int ADDR_STATUS = 1;
    localparam int ADDR_MASK   = 2;
    localparam int ADDR_RESET  = 3;
    localparam int ADDR_MODE0  = 4;

    // Trigger mode codes; 5..7 are reserved and never fire
    localparam logic [2:0] MODE_FALL = 3'd0;
    localparam logic [2:0] MODE_RISE = 3'd1;
    localparam logic [2:0] MODE_BOTH = 3'd2;
    localparam logic [2:0] MODE_LOW  = 3'd3;
    localparam logic [2:0] MODE_HIGH = 3'd4;

    localparam int MODE_W = 3;

    function automatic logic trig_hit(input logic [2:0] mode,
                                      input logic       cur,
                                      input logic       old);
        logic h;
        case (mode)
            MODE_FALL: h = old & ~cur;
            MODE_RISE: h = ~old & cur;
            MODE_BOTH: h = old ^ cur;
            MODE_LOW:  h = ~cur;
            MODE_HIGH: h = cur;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/intagg_sync.sv
module intagg_sync #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.hist = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.s2;
    assign prev_o = st_q.hist;

endmodule

// File: rtl/intagg_detect.sv
module intagg_detect
    import intagg_pkg::*;
#(
    parameter int N = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W*N-1:0] mode_i,
    input  logic [N-1:0]        lvl_i,
    input  logic [N-1:0]        prev_i,
    output logic [N-1:0]        hit_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [2:0] m;
        assign m        = mode_i[MODE_W*g +: MODE_W];
        assign hit_o[g] = trig_hit(m, lvl_i[g], prev_i[g]);

        // R4: reserved codes stay silent
        a_r4_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (m > MODE_HIGH) |-> !hit_o[g]);

        // R2: an edge-mode hit needs a real transition between history and level
        a_r2_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
            ((m <= MODE_BOTH) && hit_o[g]) |-> (lvl_i[g] != prev_i[g]));
    end

endmodule

// File: rtl/intagg_regs.sv
module intagg_regs
    import intagg_pkg::*;
#(
    parameter int         N          = 10,
    parameter int         DW         = 16,
    parameter int         AW         = 3,
    parameter int         NRST       = 8,
    parameter int         PER_REG    = 5,
    parameter logic [7:0] BOARD_ID   = 8'h03,
    parameter logic [7:0] VERSION_ID = 8'h17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    output logic [DW-1:0]       rdata_o,
    input  logic [N-1:0]        hit_i,
    output logic [MODE_W*N-1:0] mode_o,
    output logic [N-1:0]        status_o,
    output logic [N-1:0]        mask_o,
    output logic [NRST-1:0]     rst_o
);

    localparam int MREGS = (N + PER_REG - 1) / PER_REG;
    localparam int FW    = PER_REG * MODE_W;

    localparam logic [AW-1:0] A_ID     = AW'(ADDR_ID);
    localparam logic [AW-1:0] A_STATUS = AW'(ADDR_STATUS);
    localparam logic [AW-1:0] A_MASK   = AW'(ADDR_MASK);
    localparam logic [AW-1:0] A_RESET  = AW'(ADDR_RESET);

    typedef struct packed {
        logic [N-1:0]                 status;
        logic [DW-1:0]                mask;
        logic [MREGS-1:0][FW-1:0]     mode;
        logic [NRST-1:0]              rst;
    } regs_t;

    regs_t       st_d, st_q;
    logic [N-1:0] clr;
    logic        mapped;

    // Next-state
    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (we_i) begin
            if (addr_i == A_STATUS) clr = ~wdata_i[N-1:0];
            if (addr_i == A_MASK)   st_d.mask = wdata_i;
            if (addr_i == A_RESET)  st_d.rst  = wdata_i[NRST-1:0];
            for (int i = 0; i < MREGS; i++) begin
                if (addr_i == AW'(ADDR_MODE0 + i)) st_d.mode[i] = wdata_i[FW-1:0];
            end
        end
        // a trigger in the clear cycle wins
        st_d.status = (st_q.status & ~clr) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
            st_q.mode   <= '0;
            st_q.rst    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux
    always_comb begin
        rdata_o = '0;
        mapped  = 1'b1;
        case (addr_i)
            A_ID:     rdata_o = DW'({BOARD_ID, VERSION_ID});
            A_STATUS: rdata_o = DW'(st_q.status);
            A_MASK:   rdata_o = st_q.mask;
            A_RESET:  rdata_o = DW'(st_q.rst);
            default:  mapped  = 1'b0;
        endcase
        for (int i = 0; i < MREGS; i++) begin
            if (addr_i == AW'(ADDR_MODE0 + i)) begin
                rdata_o = DW'(st_q.mode[i]);
                mapped  = 1'b1;
            end
        end
    end

    // Per-source mode field placement
    for (genvar g = 0; g < N; g++) begin : g_mode
        assign mode_o[MODE_W*g +: MODE_W] =
            st_q.mode[g / PER_REG][(g % PER_REG) * MODE_W +: MODE_W];
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask[N-1:0];
    assign rst_o    = st_q.rst;

    // R5: cleared bits without a concurrent trigger are zero next cycle
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_STATUS) |=>
            ((st_q.status & ~$past(wdata_i[N-1:0]) & ~$past(hit_i)) == '0));

    // R6: every trigger is latched regardless of mask
    a_r6_hit_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((st_q.status & $past(hit_i)) == $past(hit_i)));

    // R11: reset-control lines move only on their own write
    a_r11_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == A_RESET) |=> $stable(rst_o));

    // R12: unmapped writes leave every software register alone
    a_r12_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !mapped) |=> ($stable(st_q.mask) && $stable(st_q.mode) && $stable(st_q.rst)));

endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int         NUM_SRC    = 10,
    parameter int         DATA_W     = 16,
    parameter int         ADDR_W     = 3,
    parameter int         NUM_PERIPH = 8,
    parameter int         PER_REG    = 5,
    parameter logic [7:0] BOARD_ID   = 8'h03,
    parameter logic [7:0] VERSION_ID = 8'h17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  irq_n,
    output logic [NUM_PERIPH-1:0] periph_rst_n
);

    logic [NUM_SRC-1:0]        lvl, prev, hit, status, mask;
    logic [MODE_W*NUM_SRC-1:0] mode;
    logic                      pend;

    intagg_sync #(.N(NUM_SRC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (src_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    intagg_detect #(.N(NUM_SRC)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .lvl_i  (lvl),
        .prev_i (prev),
        .hit_o  (hit)
    );

    intagg_regs #(
        .N          (NUM_SRC),
        .DW         (DATA_W),
        .AW         (ADDR_W),
        .NRST       (NUM_PERIPH),
        .PER_REG    (PER_REG),
        .BOARD_ID   (BOARD_ID),
        .VERSION_ID (VERSION_ID)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .hit_i    (hit),
        .mode_o   (mode),
        .status_o (status),
        .mask_o   (mask),
        .rst_o    (periph_rst_n)
    );

    always_comb begin
        pend  = |(status & ~mask);
        irq_n = ~pend;
    end

    // R8: an all-ones mask write releases the line next cycle
    a_r8_mask_all_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(ADDR_MASK) && (&reg_wdata)) |=> irq_n);

    // R1: first cycle out of reset shows the idle outputs
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_n && periph_rst_n == '0));

endmodule

// File: tb/sim_intagg_top.sv
`timescale 1ns/1ps
module sim_intagg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  src_i = 10'h008;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq_n;
    logic [7:0]  periph_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intagg_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n), .periph_rst_n(periph_rst_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [9:0]  m_status;
    logic [15:0] m_mask;
    logic [14:0] m_mode [2];
    logic [7:0]  m_rst;
    logic [9:0]  m_hist [$];
    logic [9:0]  m_trig, m_clr;

    function automatic bit m_fire(input int n, input bit cur, input bit old);
        int code;
        if (n < 5) code = int'(m_mode[0][3*n +: 3]);
        else       code = int'(m_mode[1][3*(n-5) +: 3]);
        case (code)
            0: return old && !cur;
            1: return !old && cur;
            2: return old != cur;
            3: return !cur;
            4: return cur;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return 16'h0317;
            3'd1: return {6'd0, m_status};
            3'd2: return m_mask;
            3'd3: return {8'd0, m_rst};
            3'd4: return {1'b0, m_mode[0]};
            3'd5: return {1'b0, m_mode[1]};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R10";
            3'd1: return "R5";
            3'd2: return "R8";
            3'd3: return "R11";
            3'd4, 3'd5: return "R9";
            default: return "R12";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = '0; m_mask = '1; m_mode[0] = '0; m_mode[1] = '0; m_rst = '0;
            m_hist = '{10'd0, 10'd0, 10'd0};
        end else begin
            for (int n = 0; n < 10; n++) m_trig[n] = m_fire(n, m_hist[1][n], m_hist[2][n]);
            m_clr = '0;
            if (reg_we) begin
                case (reg_addr)
                    3'd1: m_clr = ~reg_wdata[9:0];
                    3'd2: m_mask = reg_wdata;
                    3'd3: m_rst = reg_wdata[7:0];
                    3'd4: m_mode[0] = reg_wdata[14:0];
                    3'd5: m_mode[1] = reg_wdata[14:0];
                    default: ;
                endcase
            end
            m_status = (m_status & ~m_clr) | m_trig;
            m_hist.push_front(src_i);
            void'(m_hist.pop_back());
        end
        #1;
        if (rst_n && !done) begin
            chk(irq_n == !(|(m_status & ~m_mask[9:0])), "R7 cycle irq_n", 32'(irq_n),
                32'(!(|(m_status & ~m_mask[9:0]))));
            chk(periph_rst_n == m_rst, "R11 cycle periph_rst_n", 32'(periph_rst_n), 32'(m_rst));
            chk(reg_rdata == m_read(reg_addr), tag_of(reg_addr), 32'(reg_rdata), 32'(m_read(reg_addr)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        @(posedge clk);
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(irq_n == 1'b1, "R1 irq_n", 32'(irq_n), 32'd1);
        chk(periph_rst_n == 8'h00, "R1 periph_rst_n", 32'(periph_rst_n), 32'h0);
        rd(3'd1, d); chk(d == 16'h0000, "R1 status", 32'(d), 32'h0);
        rd(3'd2, d); chk(d == 16'hFFFF, "R1 mask", 32'(d), 32'hFFFF);
        rd(3'd4, d); chk(d == 16'h0000, "R1 mode low", 32'(d), 32'h0);

        // R10 identification, write ignored
        wr(3'd0, 16'hBEEF);
        rd(3'd0, d); chk(d == 16'h0317, "R10 id", 32'(d), 32'h0317);

        // R11 reset control
        wr(3'd3, 16'h00A5);
        chk(periph_rst_n == 8'hA5, "R11 lines", 32'(periph_rst_n), 32'hA5);
        rd(3'd3, d); chk(d == 16'h00A5, "R11 readback", 32'(d), 32'hA5);

        // R9 mode layout: low 0:rise 1:fall 2:both 3:low 4:high ; high 5:rsv5 6:rise 7:fall 8:rsv7 9:both
        wr(3'd4, 16'hC681);
        wr(3'd5, 16'h2E0D);
        rd(3'd4, d); chk(d == 16'h4681, "R9 low reg", 32'(d), 32'h4681);
        rd(3'd5, d); chk(d == 16'h2E0D, "R9 high reg", 32'(d), 32'h2E0D);
        rd(3'd1, d); chk(d == 16'h0000, "R9 no stray status", 32'(d), 32'h0);

        // R2/R6 rising edge while masked
        src_i[0] = 1'b1; idle(5); src_i[0] = 1'b0; idle(5);
        rd(3'd1, d); chk(d == 16'h0001, "R6 masked latch", 32'(d), 32'h1);
        chk(irq_n == 1'b1, "R7 masked quiet", 32'(irq_n), 32'd1);
        wr(3'd1, 16'hFFFE); idle(6);
        rd(3'd1, d); chk(d == 16'h0000, "R2 single set", 32'(d), 32'h0);

        // R5 selective clear
        src_i[0] = 1'b1; src_i[2] = 1'b1; idle(5);
        src_i[0] = 1'b0; src_i[2] = 1'b0; idle(5);
        rd(3'd1, d); chk(d == 16'h0005, "R2 rise and both", 32'(d), 32'h5);
        wr(3'd1, 16'hFFFB);
        rd(3'd1, d); chk(d == 16'h0001, "R5 keep ones", 32'(d), 32'h1);

        // R4 reserved codes
        src_i[5] = 1'b1; src_i[8] = 1'b1; idle(5);
        src_i[5] = 1'b0; src_i[8] = 1'b0; idle(5);
        rd(3'd1, d); chk(d == 16'h0001, "R4 reserved silent", 32'(d), 32'h1);

        // R3 level high, clear collides with trigger
        src_i[4] = 1'b1; idle(5);
        rd(3'd1, d); chk(d == 16'h0011, "R3 level set", 32'(d), 32'h11);
        wr(3'd1, 16'hFFEF);
        rd(3'd1, d); chk(d == 16'h0011, "R3 level resets after clear", 32'(d), 32'h11);
        src_i[4] = 1'b0; idle(5);
        wr(3'd1, 16'hFFEF);
        rd(3'd1, d); chk(d == 16'h0001, "R3 cleared after level gone", 32'(d), 32'h1);

        // R3 level low
        src_i[3] = 1'b0; idle(5);
        rd(3'd1, d); chk(d == 16'h0009, "R3 level low", 32'(d), 32'h9);
        src_i[3] = 1'b1; idle(5);
        wr(3'd1, 16'hFFF7);
        rd(3'd1, d); chk(d == 16'h0001, "R3 low cleared", 32'(d), 32'h1);

        // R7 unmasking
        wr(3'd2, 16'hFFFE);
        chk(irq_n == 1'b0, "R7 asserted", 32'(irq_n), 32'd0);
        wr(3'd2, 16'hFFFD);
        chk(irq_n == 1'b1, "R7 other bit unmasked", 32'(irq_n), 32'd1);

        // R8 re-arm pulse
        wr(3'd2, 16'hFFFE);
        chk(irq_n == 1'b0, "R8 low before", 32'(irq_n), 32'd0);
        wr(3'd2, 16'hFFFF);
        chk(irq_n == 1'b1, "R8 released", 32'(irq_n), 32'd1);
        wr(3'd2, 16'hFFFE);
        chk(irq_n == 1'b0, "R8 new edge", 32'(irq_n), 32'd0);

        // R12 unmapped space
        wr(3'd7, 16'h1234);
        wr(3'd6, 16'h0000);
        rd(3'd7, d); chk(d == 16'h0000, "R12 read zero", 32'(d), 32'h0);
        rd(3'd2, d); chk(d == 16'hFFFE, "R12 mask kept", 32'(d), 32'hFFFE);
        rd(3'd3, d); chk(d == 16'h00A5, "R12 reset ctl kept", 32'(d), 32'hA5);

        // R2 falling mode on source 7 and both-edge on 9
        src_i[7] = 1'b1; src_i[9] = 1'b1; idle(5);
        rd(3'd1, d); chk(d == 16'h0201, "R2 fall idle on rise", 32'(d), 32'h201);
        src_i[7] = 1'b0; idle(5);
        rd(3'd1, d); chk(d == 16'h0281, "R2 fall detected", 32'(d), 32'h281);

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule